// File: doc/BRIEF.md
# Serial Write-Command Receiver

This block listens on one asynchronous serial line and turns a five-byte command packet into a single write into a small internal byte memory. Each byte on the line is framed as one start bit of 0, eight data bits with the least significant bit first, and one stop bit of 1. The line is sampled sixteen times per bit. A start bit is accepted only if the line is still low at its centre, and each data bit is taken at its centre.

A packet is the command byte 0x57 (ASCII 'W'), then the upper address byte, the lower address byte, the data byte and a check byte. The check byte must equal the XOR of the four bytes before it. When it matches, the block pulses a write strobe for one clock and presents the 16-bit address and the data. The low address bits then select the memory entry that is written. A bad check byte, a bad stop bit, an unknown command byte and an idle gap in the middle of a packet each return the parser to waiting for a command.

Top module: `uart_wr_cmd_rx`

## Requirements
- R1: After reset, wr_stb, frame_err and csum_err are low, the parser waits for a command byte, and every memory entry reads 0x00.
- R2: Bytes are recovered from 8N1 frames, LSB first, at CLKS_PER_SAMPLE clocks per sample and 16 samples per bit. Any data value 0x00 to 0xFF is received exactly.
- R3: For the packet 0x57, AH, AL, D, C with C = 0x57^AH^AL^D, wr_addr = {AH,AL} and wr_data = D while wr_stb is high. From the next cycle, memory entry AL[MEM_AW-1:0] reads D.
- R4: If C differs from that XOR, csum_err is high for exactly one cycle, wr_stb stays low, and the memory is unchanged.
- R5: A stop bit sampled as 0 raises frame_err for one cycle and drops the byte. The receiver waits for the line to go high again, and the parser returns to waiting for a command.
- R6: While the parser waits for a command, any byte other than 0x57 is discarded and the parser keeps waiting.
- R7: Once a packet has started, an idle line for TIMEOUT_BITS bit times returns the parser to waiting for a command. A shorter gap lets the packet continue.
- R8: A low pulse shorter than half a bit is not taken as a start bit and produces no byte and no error.
- R9: wr_stb is high for exactly one clock cycle per accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial receive line, idle high |
| rd_addr | input | MEM_AW | Memory read index |
| rd_data | output | 8 | Memory entry at rd_addr |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Address of the last accepted packet |
| wr_data | output | 8 | Data of the last accepted packet |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| csum_err | output | 1 | One-cycle pulse on a check byte mismatch |

## Verification
The main path is swept with sixteen packets that fill every memory entry. The data values run from 0x00 to 0xFF in steps of 0x11, and the upper address bytes change from packet to packet, so bit order, bit-centre timing and the full address fields are all exercised. Further packets are built to fail in one way each: a wrong check byte, a zero stop bit followed by the rest of a packet, a stray command byte, a short gap and a long gap inside a packet, and a short low glitch. Together they separate the resync paths from one another, and each is followed by a good packet to show that the parser came back to waiting for a command.

// File: rtl/uart_wr_cmd_rx.sv
module uart_wr_cmd_rx #(
  parameter int CLKS_PER_SAMPLE = 4,
  parameter int MEM_AW          = 4,
  parameter int TIMEOUT_BITS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              wr_stb,
  output logic [15:0]       wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_err,
  output logic              csum_err
);
  localparam int PW    = (CLKS_PER_SAMPLE > 1) ? $clog2(CLKS_PER_SAMPLE) : 1;
  localparam int TLIM  = TIMEOUT_BITS * 16;
  localparam int TW    = $clog2(TLIM + 1);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [7:0] CMD_W = 8'h57;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BREAK} rx_st_t;

  logic [1:0]    rx_q;
  logic          rxs;
  logic [PW-1:0] pre;
  logic          tick;
  rx_st_t        st;
  logic [3:0]    scnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          byte_vld;
  logic [2:0]    pos;
  logic [7:0]    ah, al, dt, acc;
  logic [TW-1:0] tcnt;
  logic [7:0]    mem [DEPTH];

  assign rxs     = rx_q[1];
  assign tick    = (pre == PW'(CLKS_PER_SAMPLE - 1));
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 2'b11;
      pre  <= '0;
    end else begin
      rx_q <= {rx_q[0], rx};
      pre  <= tick ? '0 : pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scnt <= '0; bitn <= '0; sh <= '0;
      byte_vld <= 1'b0; frame_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE:  if (!rxs) begin st <= S_START; scnt <= '0; end
          S_START: if (scnt == 4'd7) begin
                     if (!rxs) begin st <= S_DATA; scnt <= '0; bitn <= '0; end
                     else st <= S_IDLE;
                   end else scnt <= scnt + 1'b1;
          S_DATA:  if (scnt == 4'd15) begin
                     sh   <= {rxs, sh[7:1]};
                     scnt <= '0;
                     bitn <= bitn + 1'b1;
                     if (bitn == 3'd7) st <= S_STOP;
                   end else scnt <= scnt + 1'b1;
          S_STOP:  if (scnt == 4'd15) begin
                     if (rxs) begin byte_vld <= 1'b1; st <= S_IDLE; end
                     else begin frame_err <= 1'b1; st <= S_BREAK; end
                   end else scnt <= scnt + 1'b1;
          default: if (rxs) st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; ah <= '0; al <= '0; dt <= '0; acc <= '0; tcnt <= '0;
      wr_stb <= 1'b0; csum_err <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_stb   <= 1'b0;
      csum_err <= 1'b0;
      if (pos == 3'd0 || st != S_IDLE || byte_vld) tcnt <= '0;
      else if (tick && tcnt != TW'(TLIM)) tcnt <= tcnt + 1'b1;
      if (frame_err) pos <= '0;
      else if (byte_vld) begin
        case (pos)
          3'd0: if (sh == CMD_W) begin pos <= 3'd1; acc <= sh; end
          3'd1: begin ah <= sh; acc <= acc ^ sh; pos <= 3'd2; end
          3'd2: begin al <= sh; acc <= acc ^ sh; pos <= 3'd3; end
          3'd3: begin dt <= sh; acc <= acc ^ sh; pos <= 3'd4; end
          default: begin
            pos <= '0;
            if (sh == acc) begin
              wr_stb  <= 1'b1;
              wr_addr <= {ah, al};
              wr_data <= dt;
            end else csum_err <= 1'b1;
          end
        endcase
      end else if (pos != 3'd0 && tcnt == TW'(TLIM)) pos <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_stb) begin
      mem[wr_addr[MEM_AW-1:0]] <= wr_data;
    end
  end

  assert_mem_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> mem[$past(wr_addr[MEM_AW-1:0])] == $past(wr_data));
  assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |=> !csum_err);
  assert_no_stb_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |-> !wr_stb);
  assert_frame_resync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> pos == 3'd0);
  assert_byte_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(st) == S_STOP);
endmodule

// File: tb/sim_uart_wr_cmd_rx.sv
module sim_uart_wr_cmd_rx;
  localparam int CPS = 4;
  localparam int AW  = 4;
  localparam int TOB = 4;
  localparam int BIT = 16 * CPS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          wr_stb, frame_err, csum_err;
  logic [15:0]   wr_addr;
  logic [7:0]    wr_data;

  int errors = 0, checks = 0;
  int nstb = 0, ncerr = 0, nferr = 0, nlong = 0;
  logic prev_stb = 1'b0;
  logic [15:0] cap_addr = '0;
  logic [7:0]  cap_data = '0;
  logic [7:0]  model [1 << AW];
  bit done = 0;

  always #4 clk = ~clk;

  uart_wr_cmd_rx #(.CLKS_PER_SAMPLE(CPS), .MEM_AW(AW), .TIMEOUT_BITS(TOB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_err(frame_err), .csum_err(csum_err));

  always @(posedge clk) begin
    if (wr_stb) begin nstb++; cap_addr = wr_addr; cap_data = wr_data; end
    if (wr_stb && prev_stb) nlong++;
    if (csum_err) ncerr++;
    if (frame_err) nferr++;
    prev_stb = wr_stb;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [7:0] b, logic stopb);
    rx = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = b[i]; repeat (BIT) @(negedge clk); end
    rx = stopb; repeat (BIT) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic send_pkt(logic [7:0] ah, logic [7:0] al, logic [7:0] d, logic [7:0] cs);
    send_frame(8'h57, 1'b1); send_frame(ah, 1'b1); send_frame(al, 1'b1);
    send_frame(d, 1'b1); send_frame(cs, 1'b1);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_mem(string req);
    for (int a = 0; a < (1 << AW); a++) begin
      rd_addr = AW'(a); #1;
      chk(req, rd_data, model[a]);
    end
  endtask

  initial begin
    for (int i = 0; i < 400000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ah, al, d;
    int s0, c0, f0;
    for (int a = 0; a < (1 << AW); a++) model[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 wr_stb", wr_stb, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 csum_err", csum_err, 0);
    check_mem("R1 mem");

    // R2/R3/R9 sweep over every entry and data 0x00..0xFF step 0x11
    for (int i = 0; i < 16; i++) begin
      ah = 8'((i * 37 + 1) & 255);
      al = 8'((i << 4) | i);
      d  = 8'(i * 17);
      s0 = nstb;
      send_pkt(ah, al, d, 8'h57 ^ ah ^ al ^ d);
      model[i] = d;
      chk("R9 one strobe", nstb - s0, 1);
      chk("R3 addr", cap_addr, {ah, al});
      chk("R2 data", cap_data, d);
      rd_addr = AW'(i); #1;
      chk("R3 mem", rd_data, d);
    end
    chk("R9 long strobe", nlong, 0);
    check_mem("R3 sweep");

    // R4 bad check byte
    s0 = nstb; c0 = ncerr;
    send_pkt(8'h12, 8'h03, 8'hC3, 8'h57 ^ 8'h12 ^ 8'h03 ^ 8'hC3 ^ 8'h01);
    chk("R4 csum_err count", ncerr - c0, 1);
    chk("R4 no strobe", nstb - s0, 0);
    check_mem("R4 mem unchanged");

    // R5 bad stop bit then rest of a packet without command byte
    s0 = nstb; f0 = nferr;
    send_frame(8'h57, 1'b1);
    send_frame(8'h00, 1'b0);
    repeat (BIT) @(negedge clk);
    send_frame(8'h03, 1'b1); send_frame(8'h05, 1'b1); send_frame(8'hAA, 1'b1);
    send_frame(8'h57 ^ 8'h03 ^ 8'h05 ^ 8'hAA, 1'b1);
    repeat (8) @(negedge clk);
    chk("R5 frame_err count", nferr - f0, 1);
    chk("R5 no strobe", nstb - s0, 0);
    check_mem("R5 mem unchanged");
    send_pkt(8'h00, 8'h05, 8'h5A, 8'h57 ^ 8'h05 ^ 8'h5A);
    model[5] = 8'h5A;
    chk("R5 resync write", nstb - s0, 1);

    // R6 stray byte before a packet
    s0 = nstb;
    send_frame(8'h52, 1'b1);
    send_pkt(8'h77, 8'h06, 8'h3C, 8'h57 ^ 8'h77 ^ 8'h06 ^ 8'h3C);
    model[6] = 8'h3C;
    chk("R6 write after stray", nstb - s0, 1);
    chk("R6 addr", cap_addr, 16'h7706);
    check_mem("R6 mem");

    // R7 short gap continues the packet
    s0 = nstb;
    send_frame(8'h57, 1'b1); send_frame(8'h01, 1'b1);
    repeat (BIT * (TOB - 2)) @(negedge clk);
    send_frame(8'h07, 1'b1); send_frame(8'h99, 1'b1);
    send_frame(8'h57 ^ 8'h01 ^ 8'h07 ^ 8'h99, 1'b1);
    repeat (8) @(negedge clk);
    model[7] = 8'h99;
    chk("R7 short gap write", nstb - s0, 1);
    // R7 long gap drops the partial packet
    s0 = nstb;
    send_frame(8'h57, 1'b1); send_frame(8'h02, 1'b1);
    repeat (BIT * (TOB + 2)) @(negedge clk);
    send_pkt(8'h02, 8'h08, 8'h81, 8'h57 ^ 8'h02 ^ 8'h08 ^ 8'h81);
    model[8] = 8'h81;
    chk("R7 timeout write", nstb - s0, 1);
    chk("R7 addr", cap_addr, 16'h0208);
    check_mem("R7 mem");

    // R8 short glitch
    s0 = nstb; c0 = ncerr; f0 = nferr;
    rx = 1'b0; repeat (BIT / 4) @(negedge clk); rx = 1'b1;
    repeat (BIT * 2) @(negedge clk);
    chk("R8 no frame_err", nferr - f0, 0);
    chk("R8 no strobe", nstb - s0, 0);
    send_pkt(8'h00, 8'h09, 8'h42, 8'h57 ^ 8'h09 ^ 8'h42);
    model[9] = 8'h42;
    chk("R8 write after glitch", nstb - s0, 1);
    chk("R8 no csum_err", ncerr - c0, 0);
    check_mem("R8 mem");
    chk("R9 long strobe end", nlong, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule